// File: doc/BRIEF.md
# Interrupt Pending, Enable and Delegation Register File

This block holds the machine-level interrupt state of a processor hart. It has four registers: interrupt pending, interrupt enable, interrupt delegation and exception delegation. It also offers two supervisor windows onto pending and enable. A supervisor window shows only the bits that the interrupt-delegation register hands down, and a write through that window changes only those bits.

Software reaches the registers through a register-style port. A 3-bit select picks the register, and a write strobe with 32-bit data commits the write on the next rising clock edge. Read data is combinational from the select. Two hardware inputs feed the machine software and machine timer pending bits; software cannot write those bits.

A level interrupt-request output is high exactly while the pending register holds any set bit. It rises when pending goes from all-zero to nonzero and falls when pending returns to all-zero. The block does no priority arbitration and no trap entry.

Top module: `intr_csr_file`

## Requirements
- R1: After a synchronous reset every register reads zero on all six select codes and the request output is low.
- R2: The interrupt-delegation register (select 2) stores only bits 1, 5, 9 and 12. Every other bit reads zero whatever was written.
- R3: The interrupt-enable register (select 1) stores only bits 1, 3, 5, 7, 9 and 12. Every other bit reads zero.
- R4: A write to the machine pending register (select 0) updates only bit 1 (supervisor software) and bit 5 (supervisor timer). Bits 3, 7, 9 and 12 are not changed by any write, and all bits other than 1, 3, 5 and 7 read zero.
- R5: Pending bit 3 takes the value of the machine software input, and pending bit 7 the value of the machine timer input, on the clock edge after the input is sampled.
- R6: A read of the supervisor pending window (select 4) returns pending AND interrupt delegation.
- R7: A write to the supervisor pending window (select 4) changes bits 1 and 5 only where they are delegated. All non-delegated bits keep their values.
- R8: A read of the supervisor enable window (select 5) returns enable AND interrupt delegation.
- R9: A write to the supervisor enable window (select 5) changes only the enable bits set in interrupt delegation. All others keep their values.
- R10: The exception-delegation register (select 3) stores only bits 0 to 9 and 11 to 15. Bit 10 and bits 16 to 31 read zero.
- R11: The request output is high in exactly those cycles in which the pending register is nonzero. It rises on a zero-to-nonzero change of pending and falls on a nonzero-to-zero change.
- R12: Select codes 6 and 7 read zero, and writes to them change no register.
- R13: Writes take effect on the rising clock edge after the strobe. Reads reflect the registers in the same cycle, without latency.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| reg_sel | input | 3 | Register select code (0..5 mapped, 6..7 unmapped) |
| wr_en | input | 1 | Write strobe for the selected register |
| wr_data | input | 32 | Write data |
| rd_data | output | 32 | Combinational read data of the selected register |
| msw_irq_in | input | 1 | Machine software interrupt level from hardware |
| mtmr_irq_in | input | 1 | Machine timer interrupt level from hardware |
| irq_req | output | 1 | Level interrupt request, high while any pending bit is set |

## Verification
Every cycle, the assertions check that the three masked registers never hold a bit outside their writable sets, and that pending bits 3 and 7 follow the hardware inputs by one edge. They also check that the software pending bits hold still without a write strobe, that a supervisor enable write leaves non-delegated enable bits alone, and that the request line rises and falls only on the zero/nonzero changes of pending. The bench scenarios show what depends on the data written: the read value of each select code after a write, the delegation filtering seen through both supervisor windows under varying delegation contents, and the ignoring of unmapped codes. These scenarios sweep walking-one, all-ones and all-zero patterns over every select code, under all four combinations of the hardware inputs.

// File: rtl/intr_csr_pkg.sv
package intr_csr_pkg;

    localparam int XLEN    = 32;
    localparam int SEL_W   = 3;

    localparam int POS_SSW = 1;
    localparam int POS_MSW = 3;
    localparam int POS_STM = 5;
    localparam int POS_MTM = 7;
    localparam int POS_SEX = 9;
    localparam int POS_COP = 12;

    localparam int EXC_LO_TOP  = 9;
    localparam int EXC_HI_BOT  = 11;
    localparam int EXC_HI_TOP  = 15;

    typedef logic [XLEN-1:0] word_t;

    typedef enum logic [SEL_W-1:0] {
        SEL_MPEND  = 3'd0,
        SEL_MENAB  = 3'd1,
        SEL_IDELEG = 3'd2,
        SEL_EDELEG = 3'd3,
        SEL_SPEND  = 3'd4,
        SEL_SENAB  = 3'd5
    } reg_sel_e;

    typedef struct packed {
        logic m_pend;
        logic m_enab;
        logic ideleg;
        logic edeleg;
        logic s_pend;
        logic s_enab;
    } wr_strobe_t;

    function automatic word_t bit_at(input int pos);
        word_t w;
        w = '0;
        w[pos] = 1'b1;
        return w;
    endfunction

    function automatic word_t bit_range(input int lo, input int hi);
        word_t w;
        w = '0;
        for (int i = 0; i < XLEN; i++) begin
            if (i >= lo && i <= hi) w[i] = 1'b1;
        end
        return w;
    endfunction

    localparam word_t DELEG_MASK = bit_at(POS_SSW) | bit_at(POS_STM) |
                                   bit_at(POS_SEX) | bit_at(POS_COP);
    localparam word_t ENAB_MASK  = DELEG_MASK | bit_at(POS_MSW) | bit_at(POS_MTM);
    localparam word_t PSW_MASK   = bit_at(POS_SSW) | bit_at(POS_STM);
    localparam word_t PHW_MASK   = bit_at(POS_MSW) | bit_at(POS_MTM);
    localparam word_t EXC_MASK   = bit_range(0, EXC_LO_TOP) |
                                   bit_range(EXC_HI_BOT, EXC_HI_TOP);

    function automatic word_t merge_bits(input word_t keep, input word_t upd,
                                         input word_t sel_mask);
        return (keep & ~sel_mask) | (upd & sel_mask);
    endfunction

endpackage

// File: rtl/intr_write_decode.sv
module intr_write_decode
    import intr_csr_pkg::*;
(
    input  logic [SEL_W-1:0] reg_sel,
    input  logic             wr_en,
    output wr_strobe_t       strobe
);
    always_comb begin
        strobe = '0;
        if (wr_en) begin
            case (reg_sel)
                SEL_MPEND:  strobe.m_pend = 1'b1;
                SEL_MENAB:  strobe.m_enab = 1'b1;
                SEL_IDELEG: strobe.ideleg = 1'b1;
                SEL_EDELEG: strobe.edeleg = 1'b1;
                SEL_SPEND:  strobe.s_pend = 1'b1;
                SEL_SENAB:  strobe.s_enab = 1'b1;
                default:    strobe = '0;
            endcase
        end
    end
endmodule

// File: rtl/intr_pending_reg.sv
module intr_pending_reg
    import intr_csr_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  m_we,
    input  logic  s_we,
    input  word_t wdata,
    input  word_t deleg,
    input  logic  msw_in,
    input  logic  mtmr_in,
    output word_t pend
);
    localparam int NSW = 2;
    localparam int SW_POS [NSW] = '{POS_SSW, POS_STM};

    logic [NSW-1:0] sw_q;
    logic           msw_q;
    logic           mtmr_q;
    word_t          cand;

    always_comb begin
        cand = pend;
        if (m_we)      cand = wdata;
        else if (s_we) cand = merge_bits(pend, wdata, deleg);
    end

    generate
        for (genvar g = 0; g < NSW; g++) begin : g_sw
            always_ff @(posedge clk) begin
                if (rst)               sw_q[g] <= 1'b0;
                else if (m_we || s_we) sw_q[g] <= cand[SW_POS[g]];
            end
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) begin
            msw_q  <= 1'b0;
            mtmr_q <= 1'b0;
        end else begin
            msw_q  <= msw_in;
            mtmr_q <= mtmr_in;
        end
    end

    always_comb begin
        pend          = '0;
        pend[POS_SSW] = sw_q[0];
        pend[POS_STM] = sw_q[1];
        pend[POS_MSW] = msw_q;
        pend[POS_MTM] = mtmr_q;
    end

    assert_hw_msw_R5: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> pend[POS_MSW] == $past(msw_in));
    assert_hw_mtmr_R5: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> pend[POS_MTM] == $past(mtmr_in));
    assert_sw_hold_R4: assert property (@(posedge clk) disable iff (rst)
        !(m_we || s_we) |=> ($stable(pend[POS_SSW]) && $stable(pend[POS_STM])));
    assert_sdeleg_hold_R7: assert property (@(posedge clk) disable iff (rst)
        (s_we && !m_we) |=> ((pend & PSW_MASK & ~$past(deleg)) ==
                             ($past(pend) & PSW_MASK & ~$past(deleg))));
endmodule

// File: rtl/intr_mask_regs.sv
module intr_mask_regs
    import intr_csr_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  wr_strobe_t strobe,
    input  word_t      wdata,
    output word_t      enab,
    output word_t      ideleg,
    output word_t      edeleg
);
    word_t enab_q;
    word_t ideleg_q;
    word_t edeleg_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            enab_q   <= '0;
            ideleg_q <= '0;
            edeleg_q <= '0;
        end else begin
            if (strobe.m_enab)
                enab_q <= wdata & ENAB_MASK;
            else if (strobe.s_enab)
                enab_q <= merge_bits(enab_q, wdata, ideleg_q) & ENAB_MASK;
            if (strobe.ideleg)
                ideleg_q <= wdata & DELEG_MASK;
            if (strobe.edeleg)
                edeleg_q <= wdata & EXC_MASK;
        end
    end

    assign enab   = enab_q;
    assign ideleg = ideleg_q;
    assign edeleg = edeleg_q;

    assert_ideleg_bits_R2: assert property (@(posedge clk) disable iff (rst)
        (ideleg & ~DELEG_MASK) == '0);
    assert_enab_bits_R3: assert property (@(posedge clk) disable iff (rst)
        (enab & ~ENAB_MASK) == '0);
    assert_edeleg_bits_R10: assert property (@(posedge clk) disable iff (rst)
        (edeleg & ~EXC_MASK) == '0);
    assert_senab_keep_R9: assert property (@(posedge clk) disable iff (rst)
        strobe.s_enab |=> ((enab & ~$past(ideleg)) == ($past(enab) & ~$past(ideleg))));
endmodule

// File: rtl/intr_csr_file.sv
module intr_csr_file
    import intr_csr_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic [SEL_W-1:0] reg_sel,
    input  logic             wr_en,
    input  logic [XLEN-1:0]  wr_data,
    output logic [XLEN-1:0]  rd_data,
    input  logic             msw_irq_in,
    input  logic             mtmr_irq_in,
    output logic             irq_req
);
    wr_strobe_t strobe;
    word_t      pend;
    word_t      enab;
    word_t      ideleg;
    word_t      edeleg;

    intr_write_decode u_dec (
        .reg_sel (reg_sel),
        .wr_en   (wr_en),
        .strobe  (strobe)
    );

    intr_pending_reg u_pend (
        .clk     (clk),
        .rst     (rst),
        .m_we    (strobe.m_pend),
        .s_we    (strobe.s_pend),
        .wdata   (wr_data),
        .deleg   (ideleg),
        .msw_in  (msw_irq_in),
        .mtmr_in (mtmr_irq_in),
        .pend    (pend)
    );

    intr_mask_regs u_mask (
        .clk    (clk),
        .rst    (rst),
        .strobe (strobe),
        .wdata  (wr_data),
        .enab   (enab),
        .ideleg (ideleg),
        .edeleg (edeleg)
    );

    always_comb begin
        case (reg_sel)
            SEL_MPEND:  rd_data = pend;
            SEL_MENAB:  rd_data = enab;
            SEL_IDELEG: rd_data = ideleg;
            SEL_EDELEG: rd_data = edeleg;
            SEL_SPEND:  rd_data = pend & ideleg;
            SEL_SENAB:  rd_data = enab & ideleg;
            default:    rd_data = '0;
        endcase
    end

    assign irq_req = |pend;

    assert_irq_rise_R11: assert property (@(posedge clk) disable iff (rst)
        $rose(irq_req) |-> ($past(pend) == '0 && pend != '0));
    assert_irq_fall_R11: assert property (@(posedge clk) disable iff (rst)
        $fell(irq_req) |-> ($past(pend) != '0 && pend == '0));
    assert_unmapped_quiet_R12: assert property (@(posedge clk) disable iff (rst)
        (wr_en && reg_sel > 3'd5) |-> $onehot0(strobe) && strobe == '0);
endmodule

// File: tb/intr_csr_file_test.sv
module intr_csr_file_test;
    localparam int PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [2:0]  reg_sel = '0;
    logic        wr_en = 1'b0;
    logic [31:0] wr_data = '0;
    logic [31:0] rd_data;
    logic        msw_irq_in = 1'b0;
    logic        mtmr_irq_in = 1'b0;
    logic        irq_req;

    int total = 0;
    int bad = 0;
    bit done = 0;

    localparam logic [31:0] K_DELEG = 32'h0000_1222;
    localparam logic [31:0] K_ENAB  = 32'h0000_12AA;
    localparam logic [31:0] K_PSW   = 32'h0000_0022;
    localparam logic [31:0] K_EXC   = 32'h0000_FBFF;

    logic [31:0] m_sw = '0, m_en = '0, m_id = '0, m_ed = '0;

    intr_csr_file uut (
        .clk(clk), .rst(rst), .reg_sel(reg_sel), .wr_en(wr_en),
        .wr_data(wr_data), .rd_data(rd_data), .msw_irq_in(msw_irq_in),
        .mtmr_irq_in(mtmr_irq_in), .irq_req(irq_req)
    );

    always #(PERIOD/2) clk = ~clk;

    function automatic logic [31:0] m_pend();
        return m_sw | ({31'b0, msw_irq_in} << 3) | ({31'b0, mtmr_irq_in} << 7);
    endfunction

    function automatic logic [31:0] exp_rd(input int s);
        case (s)
            0: return m_pend();
            1: return m_en;
            2: return m_id;
            3: return m_ed;
            4: return m_pend() & m_id;
            5: return m_en & m_id;
            default: return 32'h0;
        endcase
    endfunction

    task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s got=%h exp=%h", tag, got, exp);
        end
    endtask

    task automatic model_write(input int s, input logic [31:0] d);
        case (s)
            0: m_sw = d & K_PSW;
            1: m_en = d & K_ENAB;
            2: m_id = d & K_DELEG;
            3: m_ed = d & K_EXC;
            4: m_sw = ((m_sw & ~m_id) | (d & m_id)) & K_PSW;
            5: m_en = ((m_en & ~m_id) | (d & m_id)) & K_ENAB;
            default: ;
        endcase
    endtask

    task automatic do_write(input int s, input logic [31:0] d);
        @(negedge clk);
        reg_sel = s[2:0];
        wr_data = d;
        wr_en = 1'b1;
        @(posedge clk);
        #1 wr_en = 1'b0;
        model_write(s, d);
    endtask

    task automatic read_all(input string ctx);
        for (int s = 0; s < 8; s++) begin
            @(negedge clk);
            reg_sel = s[2:0];
            #1;
            case (s)
                0: check({ctx, " R4 mpend"}, rd_data, exp_rd(s));
                1: check({ctx, " R3 menab"}, rd_data, exp_rd(s));
                2: check({ctx, " R2 ideleg"}, rd_data, exp_rd(s));
                3: check({ctx, " R10 edeleg"}, rd_data, exp_rd(s));
                4: check({ctx, " R6 R7 spend"}, rd_data, exp_rd(s));
                5: check({ctx, " R8 R9 senab"}, rd_data, exp_rd(s));
                default: check({ctx, " R12 unmapped"}, rd_data, exp_rd(s));
            endcase
        end
        check({ctx, " R11 irq"}, {31'b0, irq_req}, {31'b0, m_pend() != 0});
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        read_all("R1 reset");

        // R5 / R13: hardware bits appear one edge after the input changes
        @(negedge clk);
        reg_sel = 3'd0;
        msw_irq_in = 1'b1;
        #1 check("R5 msw before edge", rd_data, 32'h0);
        @(posedge clk);
        #1 check("R5 msw after edge", rd_data, 32'h8);
        check("R11 irq rise", {31'b0, irq_req}, 32'h1);
        @(negedge clk);
        msw_irq_in = 1'b0;
        @(posedge clk);
        #1 check("R11 irq fall", {31'b0, irq_req}, 32'h0);

        for (int hw = 0; hw < 4; hw++) begin
            @(negedge clk);
            msw_irq_in = hw[0];
            mtmr_irq_in = hw[1];
            @(posedge clk);
            for (int s = 0; s < 8; s++) begin
                for (int p = 0; p < 34; p++) begin
                    logic [31:0] d;
                    d = (p < 32) ? (32'h1 << p) : ((p == 32) ? 32'hFFFF_FFFF : 32'h0);
                    if (s == 4 || s == 5) begin
                        do_write(2, (p[0]) ? 32'hFFFF_FFFF : (32'h1 << (p % 16)));
                        do_write(s == 4 ? 0 : 1, 32'hFFFF_FFFF ^ (32'h1 << (p % 16)));
                    end
                    do_write(s, d);
                    read_all($sformatf("hw%0d sel%0d pat%0d", hw, s, p));
                end
            end
        end

        // R12 with all registers full: writes to unmapped codes change nothing
        do_write(2, 32'hFFFF_FFFF);
        do_write(1, 32'hFFFF_FFFF);
        do_write(3, 32'hFFFF_FFFF);
        do_write(0, 32'hFFFF_FFFF);
        do_write(6, 32'h0);
        do_write(7, 32'h0);
        read_all("R12 after unmapped writes");

        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #(PERIOD * 150000);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog R13 got=timeout exp=finish");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule